// File: doc/BRIEF.md
# Serial-Slave Pause Controller

This block sits between the pins of a serial slave port and the slave's shift engine and gives the host a way to pause a transfer without losing its place. It samples the chip-select, pause request, serial clock and serial data pins into the system clock domain. It passes each serial clock edge to the engine as a one-cycle strobe, together with the data bit sampled at rising edges. While a pause is in force, it holds a registered freeze flag and stops all strobes. The engine's bit counter and shift registers therefore keep their contents and carry on from the same bit once the pause ends.

Entry to and exit from the pause both depend on the level of the serial clock. A request made while the clock is low takes effect at once. A request made while the clock is high waits for the next falling clock edge, and that falling edge still reaches the engine. Release counts only when the request line rises while the clock is low. The output driver enable for the serial data output is removed as soon as the pause pin goes low, with no synchronizer delay.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, freeze_o, eng_rise_o and eng_fall_o are 0. With cs_n_i high, so_en_o is 0.
- R2: While selected and not frozen, each rising (falling) serial clock edge produces exactly one one-cycle pulse on eng_rise_o (eng_fall_o). eng_bit_o carries the si_i level sampled with that rising edge. The pulses appear SYNC_STAGES+1 clock edges after the pin change.
- R3: hold_n_i going low while sck_i is low asserts freeze_o SYNC_STAGES+1 clock edges later.
- R4: hold_n_i going low while sck_i is high leaves freeze_o at 0 until sck_i falls. That falling edge is still delivered on eng_fall_o, and freeze_o rises with it.
- R5: If hold_n_i returns high before the deferred falling edge, no pause occurs.
- R6: While freeze_o is 1, sck_i and si_i transitions produce no eng_rise_o or eng_fall_o pulse.
- R7: freeze_o clears only after a rising edge of hold_n_i seen while sck_i is low. A rise seen with sck_i high leaves the block frozen, and a later low-then-high on hold_n_i with sck_i low releases it.
- R8: so_en_o is 1 exactly when cs_n_i is low, hold_n_i is high and freeze_o is 0. It reacts to the pins combinationally.
- R9: cs_n_i going high clears the pause. A later selection starts unfrozen.
- R10: A byte shifted MSB first with a pause at any bit position, entered with the clock at either level, arrives at the engine with the same eight bits and exactly eight rising strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| hold_n_i | input | 1 | Pause request pin, active low |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data input pin |
| freeze_o | output | 1 | Registered pause flag to the shift engine |
| eng_rise_o | output | 1 | Gated rising serial clock strobe |
| eng_fall_o | output | 1 | Gated falling serial clock strobe |
| eng_bit_o | output | 1 | Data bit captured with the rising strobe |
| so_en_o | output | 1 | Serial output driver enable |

## Verification
The assertions assume that the pins change slowly compared with the system clock: each level is held for several system clocks, so the synchronizers never drop a serial clock edge, and si_i is stable around the rising clock edges it is sampled on. The stimulus changes the pins only at falling system clock edges and holds every level for eight clocks. It keeps cs_n_i low throughout every pause except in the one directed case that exercises deselection. The sweep places the pause at every bit of a byte, once with the serial clock low and once with it high.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_ARMED  = 2'd1,
    ST_PAUSED = 2'd2
  } hold_state_t;

  // bit positions inside the synchronized pin vector
  localparam int unsigned PIN_SI   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned PIN_CS   = 3;
  localparam int unsigned PIN_W    = 4;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hold_edge.sv
module hold_edge #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] up,
  output logic [WIDTH-1:0] down
);
  logic [WIDTH-1:0] prev;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[g] <= RST_VAL[g];
      else        prev[g] <= lvl[g];
    end
    assign up[g]   =  lvl[g] & ~prev[g];
    assign down[g] = ~lvl[g] &  prev[g];
  end
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_cs_n,
  input  logic s_hold_n,
  input  logic s_sck,
  input  logic s_si,
  input  logic sck_up,
  input  logic sck_down,
  input  logic hold_up,
  output logic freeze,
  output logic eng_rise,
  output logic eng_fall,
  output logic eng_bit
);
  hold_state_t state, state_nxt;
  logic        pass;

  always_comb begin
    state_nxt = state;
    if (s_cs_n) begin
      state_nxt = ST_RUN;
    end else begin
      unique case (state)
        ST_RUN:    if (!s_hold_n) state_nxt = s_sck ? ST_ARMED : ST_PAUSED;
        ST_ARMED:  if (s_hold_n) state_nxt = ST_RUN;
                   else if (sck_down) state_nxt = ST_PAUSED;
        ST_PAUSED: if (hold_up && !s_sck) state_nxt = ST_RUN;
        default:   state_nxt = ST_RUN;
      endcase
    end
  end

  // edges reach the engine only when selected and not already paused
  assign pass = !s_cs_n && (state != ST_PAUSED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      freeze   <= 1'b0;
      eng_rise <= 1'b0;
      eng_fall <= 1'b0;
    end else begin
      state    <= state_nxt;
      freeze   <= (state_nxt == ST_PAUSED);
      eng_rise <= pass && sck_up;
      eng_fall <= pass && sck_down;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                eng_bit <= 1'b0;
    else if (pass && sck_up)   eng_bit <= s_si;
  end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic hold_n_i,
  input  logic sck_i,
  input  logic si_i,
  output logic freeze_o,
  output logic eng_rise_o,
  output logic eng_fall_o,
  output logic eng_bit_o,
  output logic so_en_o
);
  localparam logic [PIN_W-1:0] PIN_IDLE = PIN_W'(4'b1100);

  logic              rst_m, rst_q;
  logic [PIN_W-1:0]  pins, s_pins;
  logic [1:0]        lvl, up, down;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_m} <= 2'b00;
    else        {rst_q, rst_m} <= {rst_m, 1'b1};
  end

  always_comb begin
    pins           = '0;
    pins[PIN_SI]   = si_i;
    pins[PIN_SCK]  = sck_i;
    pins[PIN_HOLD] = hold_n_i;
    pins[PIN_CS]   = cs_n_i;
  end

  hold_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk(clk), .rst_n(rst_q), .d(pins), .q(s_pins)
  );

  assign lvl = {s_pins[PIN_HOLD], s_pins[PIN_SCK]};

  hold_edge #(.WIDTH(2), .RST_VAL(2'b10)) i_edge (
    .clk(clk), .rst_n(rst_q), .lvl(lvl), .up(up), .down(down)
  );

  hold_fsm i_fsm (
    .clk(clk), .rst_n(rst_q),
    .s_cs_n(s_pins[PIN_CS]), .s_hold_n(s_pins[PIN_HOLD]),
    .s_sck(s_pins[PIN_SCK]), .s_si(s_pins[PIN_SI]),
    .sck_up(up[0]), .sck_down(down[0]), .hold_up(up[1]),
    .freeze(freeze_o), .eng_rise(eng_rise_o), .eng_fall(eng_fall_o),
    .eng_bit(eng_bit_o)
  );

  // driver enable leaves the synchronizers out so the output drops at once
  assign so_en_o = !cs_n_i && hold_n_i && !freeze_o;
endmodule

// File: rtl/hold_ctrl_chk.sv
module hold_ctrl_chk (
  input logic clk,
  input logic rst_q,
  input logic cs_n_i,
  input logic hold_n_i,
  input logic s_sck,
  input logic s_hold_n,
  input logic s_cs_n,
  input logic freeze_o,
  input logic eng_rise_o,
  input logic eng_fall_o,
  input logic so_en_o
);
  // R2: one edge at a time reaches the engine
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({eng_rise_o, eng_fall_o}));

  // R3 and R4: a pause only starts with the clock low and the request active
  a_r4_enter_sck_low: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(freeze_o) |-> (!$past(s_sck) && !$past(s_hold_n)));

  // R6: no strobe while the pause holds
  a_r6_no_strobe_frozen: assert property (@(posedge clk) disable iff (!rst_q)
    (freeze_o && $past(freeze_o)) |-> (!eng_rise_o && !eng_fall_o));

  // R7 and R9: leaving a pause needs the clock low or a deselect
  a_r7_release_sck_low: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(freeze_o) |-> ($past(s_cs_n) || (!$past(s_sck) && $past(s_hold_n))));

  // R8: driver off while the request pin is low or the port is deselected
  a_r8_so_off: assert property (@(posedge clk) disable iff (!rst_q)
    (!hold_n_i || cs_n_i || freeze_o) |-> !so_en_o);
endmodule

bind spi_hold_ctrl hold_ctrl_chk i_chk (
  .clk(clk), .rst_q(rst_q), .cs_n_i(cs_n_i), .hold_n_i(hold_n_i),
  .s_sck(s_pins[hold_pkg::PIN_SCK]), .s_hold_n(s_pins[hold_pkg::PIN_HOLD]),
  .s_cs_n(s_pins[hold_pkg::PIN_CS]), .freeze_o(freeze_o),
  .eng_rise_o(eng_rise_o), .eng_fall_o(eng_fall_o), .so_en_o(so_en_o)
);

// File: tb/test_spi_hold_ctrl.sv
module test_spi_hold_ctrl;
  logic clk = 1'b0;
  logic rst_n, cs_n, hold_n, sck, si;
  logic freeze, e_rise, e_fall, e_bit, so_en;

  int errors = 0;
  int checks = 0;
  int nrise  = 0;
  int nfall  = 0;
  logic [7:0] got = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_hold_ctrl i_spi_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .sck_i(sck), .si_i(si), .freeze_o(freeze), .eng_rise_o(e_rise),
    .eng_fall_o(e_fall), .eng_bit_o(e_bit), .so_en_o(so_en)
  );

  // model of the shift engine: collects bits on rising strobes
  always @(negedge clk) begin
    if (e_rise) begin
      got   <= {got[6:0], e_bit};
      nrise <= nrise + 1;
    end
    if (e_fall) nfall <= nfall + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    si = b;   settle();
    sck = 1'b1; settle();
    sck = 1'b0; settle();
  endtask

  task automatic garbage(input logic b);
    int snap_r, snap_f;
    snap_r = nrise; snap_f = nfall;
    si = b;   sck = 1'b1; settle();
    si = ~b;  sck = 1'b0; settle();
    chk(nrise == snap_r && nfall == snap_f, "R6 strobes while frozen",
        nrise + nfall, snap_r + snap_f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; hold_n = 1'b1; sck = 1'b0; si = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1
    chk(freeze == 1'b0 && e_rise == 1'b0 && e_fall == 1'b0, "R1 reset outputs",
        {freeze, e_rise, e_fall}, 0);
    chk(so_en == 1'b0, "R1 so_en deselected", so_en, 0);

    // R2: shift timing of one edge
    cs_n = 1'b0; settle();
    chk(so_en == 1'b1, "R8 so_en selected", so_en, 1);
    si = 1'b1; settle();
    begin
      int r0;
      r0 = nrise;
      sck = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(e_rise == 1'b1 && e_bit == 1'b1, "R2 strobe latency", {e_rise, e_bit}, 3);
      @(negedge clk);
      chk(e_rise == 1'b0 && nrise == r0 + 1, "R2 single pulse", nrise - r0, 1);
    end
    sck = 1'b0; settle();
    cs_n = 1'b1; settle();

    // R10 sweep: pause at every bit position, clock low and high
    for (int pos = 0; pos < 8; pos++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        logic [7:0] val;
        int r0, f0;
        val = 8'(8'h3C ^ (pos * 37 + lvl * 91));
        cs_n = 1'b0; settle();
        r0 = nrise; f0 = nfall;
        for (int i = 0; i < 8; i++) begin
          logic b;
          b = val[7 - i];
          if (i != pos) begin
            send_bit(b);
          end else if (lvl == 0) begin
            hold_n = 1'b0;
            #1 chk(so_en == 1'b0, "R8 so_en drops at once", so_en, 0);
            settle();
            chk(freeze == 1'b1, "R3 pause with sck low", freeze, 1);
            garbage(~b);
            hold_n = 1'b1; settle();
            chk(freeze == 1'b0, "R7 resume with sck low", freeze, 0);
            send_bit(b);
          end else begin
            si = b; settle();
            sck = 1'b1; settle();
            hold_n = 1'b0; settle();
            chk(freeze == 1'b0 && so_en == 1'b0, "R4 deferred while sck high",
                {freeze, so_en}, 0);
            sck = 1'b0; settle();
            chk(freeze == 1'b1, "R4 pause at sck fall", freeze, 1);
            garbage(b);
            hold_n = 1'b1; settle();
            chk(freeze == 1'b0, "R7 resume after deferred pause", freeze, 0);
          end
        end
        chk(got == val, "R10 byte continuity", got, val);
        chk(nrise - r0 == 8 && nfall - f0 == 8, "R2 eight edges each way",
            (nrise - r0) * 100 + (nfall - f0), 808);
        cs_n = 1'b1; settle();
      end
    end

    // R7: release with sck high is blocked
    cs_n = 1'b0; settle();
    hold_n = 1'b0; settle();
    sck = 1'b1; settle();
    hold_n = 1'b1; settle();
    chk(freeze == 1'b1, "R7 blocked release sck high", freeze, 1);
    sck = 1'b0; settle();
    chk(freeze == 1'b1, "R7 still frozen after sck low", freeze, 1);
    chk(so_en == 1'b0, "R8 so_en off while frozen", so_en, 0);
    hold_n = 1'b0; settle();
    hold_n = 1'b1; settle();
    chk(freeze == 1'b0 && so_en == 1'b1, "R7 second release", {freeze, so_en}, 1);

    // R5: request withdrawn before the deferred fall
    sck = 1'b1; settle();
    hold_n = 1'b0; settle();
    hold_n = 1'b1; settle();
    sck = 1'b0; settle();
    chk(freeze == 1'b0, "R5 withdrawn request", freeze, 0);

    // R9: deselect clears the pause
    hold_n = 1'b0; settle();
    chk(freeze == 1'b1, "R9 paused before deselect", freeze, 1);
    cs_n = 1'b1; settle();
    chk(freeze == 1'b0, "R9 deselect clears", freeze, 0);
    hold_n = 1'b1; cs_n = 1'b0; settle();
    chk(freeze == 1'b0, "R9 fresh selection unfrozen", freeze, 0);
    for (int i = 0; i < 8; i++) send_bit(1'(8'hA5 >> (7 - i)));
    chk(got == 8'hA5, "R9 shifting after deselect", got, 8'hA5);
    cs_n = 1'b1; settle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule